// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a single-word-per-entry, direct-mapped cache placed between a processor request port and a slower main memory with a fixed access time. The address space is treated as pages, each the size of the cache. The low address bits select an entry. The remaining upper bits are the page number, and that page number is kept in a tag store beside each data word. A read whose page number matches a valid entry is answered from the cache one cycle after the request. In that case the memory strobe is never raised.

A read that misses starts a memory cycle. The memory answers after two wait states. The returned word is handed to the processor and also stored in the indexed entry, together with its page number. Every write goes through to memory and pays the full memory cycle. When the write hits, the cached word is also updated under the byte enables. When the write misses, the cache is not changed. Two addresses with the same low bits but different pages share one entry and evict each other.

The processor holds its request and fields stable until it sees `cpu_ready` high for one cycle. It then drops the request for at least one cycle.

Top module: `wtc_top`

## Requirements
- R1: After reset, `cpu_ready` and `mem_stb` are low and every entry is invalid, so the first read of any address misses.
- R2: The entry index is the low log2(ENTRIES) bits of `cpu_addr`, and the stored tag is the remaining upper bits.
- R3: A read whose index holds a valid entry with an equal tag raises `cpu_ready` in the cycle after the request is sampled. `cpu_rdata` then carries the cached word, and `mem_stb` stays low throughout.
- R4: A read miss raises `mem_stb` in the cycle after the request and holds it until `mem_ack` is sampled high. `mem_stb` then drops and `cpu_ready` rises in the next cycle, with `cpu_rdata` equal to the `mem_rdata` that came with the acknowledge.
- R5: A read miss fills the indexed entry with the returned word and the new tag, so a repeat read of that address hits.
- R6: A fill for one address evicts any other address with the same index and a different tag, so that other address misses on its next read.
- R7: Every write raises `mem_stb` in the cycle after the request, whether it hits or misses, and completes only after the memory acknowledge.
- R8: A write that hits replaces exactly the bytes whose `cpu_be` bit is set (bit n covers data bits 8n+7..8n) in the cached word, and keeps the entry valid with its tag.
- R9: A write that misses leaves the cache unchanged, so a later read of that address misses and returns the written memory contents.
- R10: `cpu_ready` is low during every cycle in which `mem_stb` is high.
- R11: While `mem_stb` is high, `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` equal the address, direction, enables and write data of the request being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Request valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_be | input | DATA_W/8 | Byte enables for writes |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ready` is high on a read |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_stb | output | 1 | Memory cycle strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_be | output | DATA_W/8 | Memory byte enables |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge, high in the last strobe cycle |

## Verification
A read hit must show `cpu_ready` in the first cycle after the edge that samples the request. Every miss or write must show exactly three strobe cycles, with the acknowledge in the third, followed by `cpu_ready` in the fourth. The bench drives requests on the falling edge and samples on every following falling edge. Before sampling, it predicts from its own page and tag model whether a transaction is a hit. It therefore checks strobe, ready, memory fields and read data in each of those cycles against that prediction, rather than waiting for a ready pulse.

// File: rtl/wtc_pkg.sv
// Package: shared types for the write-through cache.
package wtc_pkg;
    // Controller sequencing: wait for a request, run a memory cycle, present the response.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_RESP = 2'd2
    } wtc_state_e;
endpackage

// File: rtl/wtc_match.sv
// Module: wtc_match
// Splits the request address into entry index and page tag, and compares the
// page tag with the tag stored at that index. Purely combinational. Assumes the
// store answers reads combinationally for the index it is given.
module wtc_match #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    output logic [IDX_W-1:0]  idx,
    output logic              hit
);
    // Index from low bits, hit when the entry is valid and holds the same page.
    always_comb begin
        idx = addr[IDX_W-1:0];
        hit = ent_valid && (ent_tag == addr[ADDR_W-1:IDX_W]);
    end
endmodule

// File: rtl/wtc_store.sv
// Module: wtc_store
// Holds the valid bits, tags and data words, one word per entry. Reads are
// combinational; a write sets the entry valid with the given tag and word.
// Only valid bits are reset; tag and data contents are don't-care while invalid.
module wtc_store #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 12,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [DATA_W-1:0]  data_q [ENTRIES];

    // Valid bits: cleared on reset, set by any fill or write-hit update.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else if (wr_en) valid_q[wr_idx] <= 1'b1;
    end

    // Tag and data storage, written on the same strobe as the valid bit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    // Combinational read port for the lookup.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_data  = data_q[rd_idx];
    end

    // A written entry is valid from the next cycle on.
    assert_write_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/wtc_ctrl.sv
// Module: wtc_ctrl
// Sequences each request. A read hit is answered from the cache with one cycle
// of latency. A read miss or any write runs one memory cycle that ends on the
// memory acknowledge. A read miss fills the entry; a write hit merges its bytes
// into the entry. Assumes the request fields stay stable until cpu_ready.
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - IDX_W,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              mem_stb,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BE_W-1:0]   mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data
);
    wtc_state_e        state_q;
    logic              stb_q;
    logic              we_q;
    logic              hit_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] old_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] merged;

    // State and strobe: start a memory cycle unless the request is a read hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stb_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (cpu_req) begin
                    if (!cpu_we && lk_hit) begin
                        state_q <= ST_RESP;
                    end else begin
                        state_q <= ST_MEM;
                        stb_q   <= 1'b1;
                    end
                end
                ST_MEM: if (mem_ack) begin
                    state_q <= ST_RESP;
                    stb_q   <= 1'b0;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Request capture: latch the fields and the lookup outcome when a request is taken.
    always_ff @(posedge clk) begin
        if (state_q == ST_IDLE && cpu_req) begin
            we_q    <= cpu_we;
            hit_q   <= lk_hit;
            addr_q  <= cpu_addr;
            be_q    <= cpu_be;
            wdata_q <= cpu_wdata;
            old_q   <= lk_data;
        end
    end

    // Read data: the cached word on a hit, or the memory word on the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (state_q == ST_IDLE && cpu_req && !cpu_we && lk_hit) rdata_q <= lk_data;
        else if (state_q == ST_MEM && mem_ack && !we_q) rdata_q <= mem_rdata;
    end

    // Byte merge of the write data into the previously cached word.
    always_comb begin
        for (int b = 0; b < BE_W; b++) begin
            merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : old_q[8*b +: 8];
        end
    end

    // Cache update: fill on read miss, merge on write hit, nothing on write miss.
    always_comb begin
        wr_en   = (state_q == ST_MEM) && mem_ack && (!we_q || hit_q);
        wr_idx  = addr_q[IDX_W-1:0];
        wr_tag  = addr_q[ADDR_W-1:IDX_W];
        wr_data = we_q ? merged : mem_rdata;
    end

    // Port outputs.
    always_comb begin
        cpu_ready = (state_q == ST_RESP);
        cpu_rdata = rdata_q;
        mem_stb   = stb_q;
        mem_we    = we_q;
        mem_addr  = addr_q;
        mem_be    = be_q;
        mem_wdata = wdata_q;
    end

    // The strobe is held until the acknowledge is seen.
    assert_stb_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && !mem_ack) |=> mem_stb);
    // The acknowledge ends the strobe and completes the request next cycle.
    assert_ack_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && mem_ack) |=> (!mem_stb && cpu_ready));
    // No completion pulse while memory is busy.
    assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stb |-> !cpu_ready);
    // Completion is a single-cycle pulse.
    assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
    // Every taken write raises the strobe.
    assert_write_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_stb && !cpu_ready && cpu_req && cpu_we) |=> mem_stb);
    // Memory fields stay constant across a strobe.
    assert_mem_fields_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && $past(mem_stb)) |-> ($stable(mem_addr) && $stable(mem_we)));
endmodule

// File: rtl/wtc_top.sv
// Module: wtc_top
// Direct-mapped, write-through cache with one word per entry and no
// write-allocate. Index and tag widths derive from ADDR_W and ENTRIES.
// Assumes main memory acknowledges within its fixed access time.
module wtc_top #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = ADDR_W - IDX_W,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_stb,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BE_W-1:0]   mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic [IDX_W-1:0]  lk_idx;
    logic              lk_valid;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_data;
    logic              lk_hit;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    wtc_match #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
        .addr      (cpu_addr),
        .ent_valid (lk_valid),
        .ent_tag   (lk_tag),
        .idx       (lk_idx),
        .hit       (lk_hit)
    );

    wtc_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_valid (lk_valid),
        .rd_tag   (lk_tag),
        .rd_data  (lk_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data)
    );

    wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_be    (cpu_be),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready),
        .lk_hit    (lk_hit),
        .lk_data   (lk_data),
        .mem_stb   (mem_stb),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_data   (wr_data)
    );
endmodule

// File: tb/wtc_top_tb.sv
// Bench: drives requests on falling edges, models memory with two wait states,
// and predicts every cycle of each transaction from a behavioural cache model.
module wtc_top_tb;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int ENTRIES = 16;
    localparam int BE_W = DATA_W / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [BE_W-1:0] cpu_be = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic cpu_ready, mem_stb, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [BE_W-1:0] mem_be;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wtc_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_stb(mem_stb),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [DATA_W-1:0] init_val(int a);
        return DATA_W'(a) * 32'h9E3779B1 ^ 32'h5A5A0000;
    endfunction

    function automatic logic [DATA_W-1:0] merge(logic [DATA_W-1:0] o, logic [DATA_W-1:0] n,
                                                logic [BE_W-1:0] be);
        logic [DATA_W-1:0] r = o;
        for (int b = 0; b < BE_W; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    // Memory side: acknowledge in the third strobe cycle.
    logic [DATA_W-1:0] slave_mem [int];
    int wcnt = 0;
    assign mem_ack = mem_stb && (wcnt == 2);
    assign mem_rdata = slave_mem.exists(int'(mem_addr)) ? slave_mem[int'(mem_addr)]
                                                        : init_val(int'(mem_addr));
    always @(posedge clk) begin
        if (mem_stb && mem_ack && mem_we)
            slave_mem[int'(mem_addr)] = merge(mem_rdata, mem_wdata, mem_be);
        wcnt <= (mem_stb && wcnt < 2) ? wcnt + 1 : 0;
    end

    // Reference model state.
    logic [DATA_W-1:0] ref_mem [int];
    bit m_valid [ENTRIES];
    int m_tag [ENTRIES];
    logic [DATA_W-1:0] m_data [ENTRIES];

    function automatic logic [DATA_W-1:0] ref_rd(int a);
        return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
    endfunction

    task automatic chk(bit ok, string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // One transaction, checked in every cycle until completion.
    task automatic xact(bit we, int a, logic [BE_W-1:0] be, logic [DATA_W-1:0] wd);
        int idx = a % ENTRIES;         // R2: index = low bits
        int tg = a / ENTRIES;          // R2: tag = upper bits
        bit hit = m_valid[idx] && m_tag[idx] == tg;
        logic [DATA_W-1:0] exp_rd;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(a); cpu_be = be; cpu_wdata = wd;
        if (!we && hit) begin
            @(negedge clk);
            chk(cpu_ready === 1'b1, "R3 hit ready", DATA_W'(cpu_ready), 1);
            chk(mem_stb === 1'b0, "R3 hit no strobe", DATA_W'(mem_stb), 0);
            chk(cpu_rdata === m_data[idx], "R3 hit data", cpu_rdata, m_data[idx]);
        end else begin
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                chk(mem_stb === 1'b1, we ? "R7 write strobe" : "R4 miss strobe", DATA_W'(mem_stb), 1);
                chk(cpu_ready === 1'b0, "R10 ready low", DATA_W'(cpu_ready), 0);
                chk(mem_addr === ADDR_W'(a), "R11 mem addr", DATA_W'(mem_addr), DATA_W'(a));
                chk(mem_we === we, "R11 mem we", DATA_W'(mem_we), DATA_W'(we));
                if (we) begin
                    chk(mem_wdata === wd, "R11 mem wdata", mem_wdata, wd);
                    chk(mem_be === be, "R11 mem be", DATA_W'(mem_be), DATA_W'(be));
                end
            end
            @(negedge clk);
            chk(cpu_ready === 1'b1, "R4 ready after ack", DATA_W'(cpu_ready), 1);
            chk(mem_stb === 1'b0, "R4 strobe released", DATA_W'(mem_stb), 0);
            if (we) begin
                ref_mem[a] = merge(ref_rd(a), wd, be);
                if (hit) m_data[idx] = merge(m_data[idx], wd, be);   // R8 merge, R9 no allocate
            end else begin
                exp_rd = ref_rd(a);
                chk(cpu_rdata === exp_rd, "R4 miss data", cpu_rdata, exp_rd);
                m_valid[idx] = 1'b1; m_tag[idx] = tg; m_data[idx] = exp_rd;   // R5, R6
            end
        end
        cpu_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(cpu_ready === 1'b0, "R1 reset ready", DATA_W'(cpu_ready), 0);
        chk(mem_stb === 1'b0, "R1 reset strobe", DATA_W'(mem_stb), 0);
        for (int i = 0; i < ENTRIES; i++) m_valid[i] = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        xact(0, 'h0013, '1, 0);                 // R1 first read misses
        xact(0, 'h0013, '1, 0);                 // R5 refill hits
        xact(0, 'h0103, '1, 0);                 // R6 same index, other tag
        xact(0, 'h0013, '1, 0);                 // R6 evicted -> miss
        xact(1, 'h0013, 4'b0101, 32'hAABBCCDD); // R7 write hit still strobes, R8
        xact(0, 'h0013, '1, 0);                 // R8 merged data hits
        xact(1, 'h0027, 4'b1111, 32'h12345678); // R9 write miss
        xact(0, 'h0027, '1, 0);                 // R9 still a miss, returns written word
        xact(0, 'h0027, '1, 0);
        for (int i = 0; i < ENTRIES; i++) xact(0, 'h0400 + i, '1, 0);   // R2 fill all indices
        for (int i = 0; i < ENTRIES; i++) xact(0, 'h0400 + i, '1, 0);   // R3 all hit
        xact(1, 'h0405, 4'b1000, 32'hFF000000); // R8 top byte only
        xact(0, 'h0405, '1, 0);
        xact(0, 'hF405, '1, 0);                 // R2 top tag bits distinguish
        xact(0, 'h0405, '1, 0);
        do_reset();                             // R1 entries invalid again
        xact(0, 'h0400, '1, 0);
        xact(0, 'h0400, '1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R4 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule